// File: doc/BRIEF.md
# I/O Translation Unit Control Registers

This block is the software-visible register file that configures an I/O address translation unit. A host reaches it through a plain word-addressed port: a byte offset divided by four selects a 32-bit word. Reads are combinational and return the addressed word in the same cycle. A write on an active clock edge updates the selected register. Each register keeps only the bits that its own write mask allows, and some registers force fixed bits on.

The translator reads the configuration from dedicated outputs: the translation enable, the page-table base and the start address of the I/O window. The window start is decoded from a three-bit size code when the control word is written. The two flush registers do not act on any lookup cache. They store the written value and raise a one-cycle pulse that carries it, so a neighbouring cache can invalidate itself. Any word address inside the implemented range that has no defined register acts as plain 32-bit storage.

Top module: `iommu_regfile`

## Requirements
- R1: After reset the control word (word 0x000) reads 0x04000000, every other word reads 0, and windowStart, pageTableBase, xlateEnable, tlbFlushPulse and pgFlushPulse are 0.
- R2: A write to word 0x000 stores only data bits under 0x0000001D and always sets 0x04000000, so the read-back equals (data & 0x1D) | 0x04000000.
- R3: xlateEnable equals bit 0 of the stored control word from the cycle after a control write.
- R4: On a control write, windowStart is loaded from the size code in data bits [4:2]: 0→0xFF000000, 1→0xFE000000, 2→0xFC000000, 3→0xF8000000, 4→0xF0000000, 5→0xE0000000, 6→0xC0000000, 7→0x80000000. It does not change on any other cycle.
- R5: A write to word 0x001 stores data & 0x07FFFC00, and that value is driven on pageTableBase.
- R6: A write to word 0x005 stores the full data word. In the following cycle only, tlbFlushPulse is 1 and flushData carries the data.
- R7: A write to word 0x006 stores the full data word. In the following cycle only, pgFlushPulse is 1 and flushData carries the data.
- R8: Words 0x404 to 0x407 are four per-slot configuration registers. Each one stores data & 0x00010003: bit 16 is the substitute address bit 30 for bypass, bit 1 is 8-byte burst support and bit 0 is bypass.
- R9: A write to word 0x800 stores (data & 0x001F0000) | 0x00000008.
- R10: A word below NUM_WORDS with no defined register stores and returns the full 32-bit data. A write at or above NUM_WORDS is ignored, and reads there return 0.
- R11: busRdData shows the addressed word in the same cycle. During a write cycle it still shows the old value, and the new value appears from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Write strobe for the addressed word |
| busAddr | input | ADDR_W | Word address (byte offset >> 2) |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Combinational read data of the addressed word |
| xlateEnable | output | 1 | Translation enable |
| pageTableBase | output | 32 | Masked page-table base |
| windowStart | output | 32 | Start address of the I/O window |
| tlbFlushPulse | output | 1 | One-cycle pulse after a full-flush write |
| pgFlushPulse | output | 1 | One-cycle pulse after a page-flush write |
| flushData | output | 32 | Data of the latest flush write |

## Verification
The hardest case to reach is the gap between the stored control word and the window start. At reset the stored size code is 0, yet the window start must be zero rather than the code-0 value, and only a write moves it. The stimulus therefore checks the window right after reset. It then walks all eight size codes through separate control writes. Finally it writes a word whose only set bit is outside the mask, which must bring back the code-0 window while the read-back shows only the version bit.

// File: rtl/iommu_regfile_pkg.sv
package iommu_regfile_pkg;

  localparam logic [31:0] CTRL_WORD   = 32'h0000_0000;
  localparam logic [31:0] BASE_WORD   = 32'h0000_0001;
  localparam logic [31:0] TLBF_WORD   = 32'h0000_0005;
  localparam logic [31:0] PGF_WORD    = 32'h0000_0006;
  localparam logic [31:0] SLOT_WORD0  = 32'h0000_0404;
  localparam logic [31:0] ARB_WORD    = 32'h0000_0800;

  localparam logic [31:0] CTRL_MASK   = 32'h0000_001D;
  localparam logic [31:0] CTRL_FIXED  = 32'h0400_0000;
  localparam logic [31:0] BASE_MASK   = 32'h07FF_FC00;
  localparam logic [31:0] SLOT_MASK   = 32'h0001_0003;
  localparam logic [31:0] ARB_MASK    = 32'h001F_0000;
  localparam logic [31:0] ARB_FIXED   = 32'h0000_0008;
  localparam logic [31:0] WIN_UNIT    = 32'h0100_0000;

  typedef enum logic [2:0] {
    RD_CTRL, RD_BASE, RD_TLBF, RD_PGF, RD_SLOT, RD_ARB, RD_SPARE, RD_NONE
  } rdSel_e;

  typedef struct packed {
    logic   wrCtrl;
    logic   wrBase;
    logic   wrTlbFlush;
    logic   wrPgFlush;
    logic   wrSlot;
    logic   wrArb;
    logic   wrSpare;
    rdSel_e rdSel;
  } regStrobe_t;

endpackage

// File: rtl/iommu_regfile_dec.sv
module iommu_regfile_dec
  import iommu_regfile_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int NUM_WORDS  = 3072,
  parameter int NUM_SLOTS  = 4,
  parameter int SLOT_IDX_W = 2
) (
  input  logic                  busWrEn,
  input  logic [ADDR_W-1:0]     busAddr,
  output regStrobe_t            stb,
  output logic [SLOT_IDX_W-1:0] slotIdx
);

  logic [31:0] addrWide;
  logic        inSlots;
  logic        inRange;

  assign addrWide = 32'(busAddr);
  assign inSlots  = (addrWide >= SLOT_WORD0) && (addrWide < SLOT_WORD0 + 32'(NUM_SLOTS));
  assign inRange  = addrWide < 32'(NUM_WORDS);
  assign slotIdx  = SLOT_IDX_W'(addrWide - SLOT_WORD0);

  always_comb begin
    stb       = '0;
    stb.rdSel = RD_NONE;
    if (addrWide == CTRL_WORD)      stb.rdSel = RD_CTRL;
    else if (addrWide == BASE_WORD) stb.rdSel = RD_BASE;
    else if (addrWide == TLBF_WORD) stb.rdSel = RD_TLBF;
    else if (addrWide == PGF_WORD)  stb.rdSel = RD_PGF;
    else if (inSlots)               stb.rdSel = RD_SLOT;
    else if (addrWide == ARB_WORD)  stb.rdSel = RD_ARB;
    else if (inRange)               stb.rdSel = RD_SPARE;

    stb.wrCtrl     = busWrEn && (stb.rdSel == RD_CTRL);
    stb.wrBase     = busWrEn && (stb.rdSel == RD_BASE);
    stb.wrTlbFlush = busWrEn && (stb.rdSel == RD_TLBF);
    stb.wrPgFlush  = busWrEn && (stb.rdSel == RD_PGF);
    stb.wrSlot     = busWrEn && (stb.rdSel == RD_SLOT);
    stb.wrArb      = busWrEn && (stb.rdSel == RD_ARB);
    stb.wrSpare    = busWrEn && (stb.rdSel == RD_SPARE);
  end

endmodule

// File: rtl/iommu_regfile_dp.sv
module iommu_regfile_dp
  import iommu_regfile_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int NUM_WORDS  = 3072,
  parameter int NUM_SLOTS  = 4,
  parameter int SLOT_IDX_W = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  regStrobe_t            stb,
  input  logic [SLOT_IDX_W-1:0] slotIdx,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [31:0]           busWrData,
  output logic [31:0]           busRdData,
  output logic                  xlateEnable,
  output logic [31:0]           pageTableBase,
  output logic [31:0]           windowStart,
  output logic                  tlbFlushPulse,
  output logic                  pgFlushPulse,
  output logic [31:0]           flushData
);

  logic [31:0] ctrlReg, baseReg, tlbReg, pgReg, arbReg, winReg;
  logic [31:0] slotReg [NUM_SLOTS];
  logic [31:0] spareMem [NUM_WORDS];

  function automatic logic [31:0] windowFromCode(input logic [2:0] code);
    return 32'(0) - (WIN_UNIT << code);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= CTRL_FIXED;
      winReg  <= '0;
    end else if (stb.wrCtrl) begin
      ctrlReg <= (busWrData & CTRL_MASK) | CTRL_FIXED;
      winReg  <= windowFromCode(busWrData[4:2]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) baseReg <= '0;
    else if (stb.wrBase) baseReg <= busWrData & BASE_MASK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tlbReg        <= '0;
      pgReg         <= '0;
      tlbFlushPulse <= 1'b0;
      pgFlushPulse  <= 1'b0;
      flushData     <= '0;
    end else begin
      tlbFlushPulse <= stb.wrTlbFlush;
      pgFlushPulse  <= stb.wrPgFlush;
      if (stb.wrTlbFlush) tlbReg <= busWrData;
      if (stb.wrPgFlush)  pgReg  <= busWrData;
      if (stb.wrTlbFlush || stb.wrPgFlush) flushData <= busWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) arbReg <= '0;
    else if (stb.wrArb) arbReg <= (busWrData & ARB_MASK) | ARB_FIXED;
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : gSlot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) slotReg[g] <= '0;
      else if (stb.wrSlot && (slotIdx == SLOT_IDX_W'(g)))
        slotReg[g] <= busWrData & SLOT_MASK;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_WORDS; i++) spareMem[i] <= '0;
    end else if (stb.wrSpare) begin
      spareMem[busAddr] <= busWrData;
    end
  end

  always_comb begin
    unique case (stb.rdSel)
      RD_CTRL:  busRdData = ctrlReg;
      RD_BASE:  busRdData = baseReg;
      RD_TLBF:  busRdData = tlbReg;
      RD_PGF:   busRdData = pgReg;
      RD_SLOT:  busRdData = slotReg[slotIdx];
      RD_ARB:   busRdData = arbReg;
      RD_SPARE: busRdData = spareMem[busAddr];
      default:  busRdData = '0;
    endcase
  end

  assign xlateEnable   = ctrlReg[0];
  assign pageTableBase = baseReg;
  assign windowStart   = winReg;

endmodule

// File: rtl/iommu_regfile.sv
module iommu_regfile
  import iommu_regfile_pkg::*;
#(
  parameter int NUM_WORDS = 3072,
  parameter int ADDR_W    = 12,
  parameter int NUM_SLOTS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  output logic              xlateEnable,
  output logic [31:0]       pageTableBase,
  output logic [31:0]       windowStart,
  output logic              tlbFlushPulse,
  output logic              pgFlushPulse,
  output logic [31:0]       flushData
);

  localparam int SLOT_IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  regStrobe_t            stb;
  logic [SLOT_IDX_W-1:0] slotIdx;

  iommu_regfile_dec #(
    .ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS),
    .NUM_SLOTS(NUM_SLOTS), .SLOT_IDX_W(SLOT_IDX_W)
  ) u_dec (
    .busWrEn(busWrEn), .busAddr(busAddr), .stb(stb), .slotIdx(slotIdx)
  );

  iommu_regfile_dp #(
    .ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS),
    .NUM_SLOTS(NUM_SLOTS), .SLOT_IDX_W(SLOT_IDX_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .slotIdx(slotIdx),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .xlateEnable(xlateEnable), .pageTableBase(pageTableBase),
    .windowStart(windowStart), .tlbFlushPulse(tlbFlushPulse),
    .pgFlushPulse(pgFlushPulse), .flushData(flushData)
  );

endmodule

// File: rtl/iommu_regfile_chk.sv
module iommu_regfile_chk
  import iommu_regfile_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWrEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWrData,
  input logic [31:0]       busRdData,
  input logic              xlateEnable,
  input logic [31:0]       pageTableBase,
  input logic [31:0]       windowStart,
  input logic              tlbFlushPulse,
  input logic              pgFlushPulse,
  input logic [31:0]       flushData
);

  logic [31:0] aW;
  assign aW = 32'(busAddr);

  AST_CTRL_FIXED_BITS: assert property (@(posedge clk) disable iff (!rstN)
    (aW == CTRL_WORD) |-> ((busRdData & ~(CTRL_MASK | CTRL_FIXED)) == 0 && busRdData[26])); // R2

  AST_ENABLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && aW == CTRL_WORD) |=> (xlateEnable == $past(busWrData[0]))); // R3

  AST_WINDOW_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !(busWrEn && aW == CTRL_WORD) |=> $stable(windowStart)); // R4

  AST_BASE_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (pageTableBase & ~BASE_MASK) == 0); // R5

  AST_TLB_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && aW == TLBF_WORD) |=> (tlbFlushPulse && flushData == $past(busWrData))); // R6

  AST_TLB_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !(busWrEn && aW == TLBF_WORD) |=> !tlbFlushPulse); // R6

  AST_PG_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && aW == PGF_WORD) |=> (pgFlushPulse && flushData == $past(busWrData))); // R7

  AST_PG_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !(busWrEn && aW == PGF_WORD) |=> !pgFlushPulse); // R7

  AST_SLOT_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (aW >= SLOT_WORD0 && aW < SLOT_WORD0 + 32'd4) |-> ((busRdData & ~SLOT_MASK) == 0)); // R8

  AST_ARB_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (aW == ARB_WORD) |-> ((busRdData & ~(ARB_MASK | ARB_FIXED)) == 0)); // R9

  AST_ARB_FORCED: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && aW == ARB_WORD) |=> (aW != ARB_WORD || busRdData[3])); // R9

endmodule

bind iommu_regfile iommu_regfile_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
  .busWrData(busWrData), .busRdData(busRdData), .xlateEnable(xlateEnable),
  .pageTableBase(pageTableBase), .windowStart(windowStart),
  .tlbFlushPulse(tlbFlushPulse), .pgFlushPulse(pgFlushPulse),
  .flushData(flushData)
);

// File: tb/sim_iommu_regfile.sv
`timescale 1ns/1ps
module sim_iommu_regfile;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 12;

  localparam int K_RD  = 0;
  localparam int K_WIN = 1;
  localparam int K_BAS = 2;
  localparam int K_EN  = 3;
  localparam int K_TP  = 4;
  localparam int K_PP  = 5;
  localparam int K_FD  = 6;

  typedef struct {
    string       tag;
    int          kind;
    logic [31:0] exp;
  } item_t;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              busWrEn = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [31:0]       busWrData = '0;
  logic [31:0]       busRdData, pageTableBase, windowStart, flushData;
  logic              xlateEnable, tlbFlushPulse, pgFlushPulse;

  item_t expQ[$];
  int    checks = 0;
  int    failures = 0;
  bit    finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  iommu_regfile u0 (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .xlateEnable(xlateEnable),
    .pageTableBase(pageTableBase), .windowStart(windowStart),
    .tlbFlushPulse(tlbFlushPulse), .pgFlushPulse(pgFlushPulse),
    .flushData(flushData)
  );

  function automatic logic [31:0] observe(input int kind);
    case (kind)
      K_RD:    return busRdData;
      K_WIN:   return windowStart;
      K_BAS:   return pageTableBase;
      K_EN:    return 32'(xlateEnable);
      K_TP:    return 32'(tlbFlushPulse);
      K_PP:    return 32'(pgFlushPulse);
      default: return flushData;
    endcase
  endfunction

  // Monitor: a quarter period after each falling edge, drain the queue.
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      while (expQ.size() > 0) begin
        item_t it;
        logic [31:0] got;
        it  = expQ.pop_front();
        got = observe(it.kind);
        checks++;
        if (got !== it.exp) begin
          failures++;
          $display("FAIL %s kind=%0d actual=%08h expected=%08h", it.tag, it.kind, got, it.exp);
        end
      end
    end
  end

  task automatic push(input string tag, input int kind, input logic [31:0] exp);
    item_t it;
    it.tag = tag; it.kind = kind; it.exp = exp;
    expQ.push_back(it);
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    busWrEn = 1'b0; busAddr = a; busWrData = '0;
    push(tag, K_RD, exp);
  endtask

  function automatic logic [31:0] winFor(input int code);
    case (code)
      0: return 32'hFF00_0000;
      1: return 32'hFE00_0000;
      2: return 32'hFC00_0000;
      3: return 32'hF800_0000;
      4: return 32'hF000_0000;
      5: return 32'hE000_0000;
      6: return 32'hC000_0000;
      default: return 32'h8000_0000;
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(12'h000, 32'h0400_0000, "R1");
    push("R1", K_WIN, 32'h0);
    push("R1", K_EN, 32'h0);
    push("R1", K_BAS, 32'h0);
    push("R1", K_TP, 32'h0);
    push("R1", K_PP, 32'h0);
    rd(12'h001, 32'h0, "R1");
    rd(12'h005, 32'h0, "R1");
    rd(12'h404, 32'h0, "R1");
    rd(12'h800, 32'h0, "R1");
    rd(12'h100, 32'h0, "R1");

    // R2 R3 R4: all ones
    wr(12'h000, 32'hFFFF_FFFF);
    rd(12'h000, 32'h0400_001D, "R2");
    push("R3", K_EN, 32'h1);
    push("R4", K_WIN, 32'h8000_0000);

    // R4 every size code
    for (int c = 0; c < 8; c++) begin
      wr(12'h000, 32'(c) << 2);
      rd(12'h000, 32'h0400_0000 | (32'(c) << 2), "R2");
      push("R4", K_WIN, winFor(c));
      push("R3", K_EN, 32'h0);
    end

    // R2 bit outside the mask only; window back to code 0
    wr(12'h000, 32'h0000_0002);
    rd(12'h000, 32'h0400_0000, "R2");
    push("R4", K_WIN, 32'hFF00_0000);
    // R4 window unchanged by non-control writes
    wr(12'h001, 32'hFFFF_FFFF);
    rd(12'h001, 32'h07FF_FC00, "R5");
    push("R5", K_BAS, 32'h07FF_FC00);
    push("R4", K_WIN, 32'hFF00_0000);
    wr(12'h001, 32'h1234_5678);
    rd(12'h001, 32'h0234_5400, "R5");
    push("R5", K_BAS, 32'h0234_5400);

    // R6 full flush
    wr(12'h005, 32'hA5A5_5A5A);
    rd(12'h005, 32'hA5A5_5A5A, "R6");
    push("R6", K_TP, 32'h1);
    push("R6", K_PP, 32'h0);
    push("R6", K_FD, 32'hA5A5_5A5A);
    rd(12'h005, 32'hA5A5_5A5A, "R6");
    push("R6", K_TP, 32'h0);

    // R7 page flush
    wr(12'h006, 32'h0000_1234);
    rd(12'h006, 32'h0000_1234, "R7");
    push("R7", K_PP, 32'h1);
    push("R7", K_TP, 32'h0);
    push("R7", K_FD, 32'h0000_1234);
    rd(12'h005, 32'hA5A5_5A5A, "R7");
    push("R7", K_PP, 32'h0);

    // R8 slot configuration
    wr(12'h404, 32'hFFFF_FFFF);
    wr(12'h405, 32'h0000_0004);
    wr(12'h406, 32'h0001_0002);
    wr(12'h407, 32'h0000_0001);
    rd(12'h404, 32'h0001_0003, "R8");
    rd(12'h405, 32'h0000_0000, "R8");
    rd(12'h406, 32'h0001_0002, "R8");
    rd(12'h407, 32'h0000_0001, "R8");

    // R9 arbitration enable
    wr(12'h800, 32'hFFFF_FFFF);
    rd(12'h800, 32'h001F_0008, "R9");
    wr(12'h800, 32'h0000_0000);
    rd(12'h800, 32'h0000_0008, "R9");

    // R10 plain storage and out-of-range
    wr(12'h100, 32'hCAFE_F00D);
    wr(12'h408, 32'h1111_2222);
    wr(12'hC00, 32'hDEAD_BEEF);
    rd(12'h100, 32'hCAFE_F00D, "R10");
    rd(12'h408, 32'h1111_2222, "R10");
    rd(12'hC00, 32'h0000_0000, "R10");
    rd(12'h407, 32'h0000_0001, "R10");

    // R11 old value during write, new value next cycle
    wr(12'h100, 32'h0BAD_CAFE);
    push("R11", K_RD, 32'hCAFE_F00D);
    rd(12'h100, 32'h0BAD_CAFE, "R11");

    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule